// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Access Protection

This block maps a 32-bit virtual address to a physical address through a small set-associative translation buffer. Every entry describes its own page, either 1 KiB or 4 KiB, and the page size decides which virtual address bits take part in the tag match and which physical page bits reach the output. An entry can be tied to one address space through an 8-bit space identifier or marked as shared by every space. Each entry also carries a two-bit access-rights code, a cacheable flag and a modified flag.

The requester drives a lookup with the address, the current space identifier, a privilege flag and a read/write flag. One clock later the block reports exactly one outcome: a hit with the physical address and cacheable flag, a miss, a rights violation, or a first-write fault on a page that has never been modified. A refill port writes one way of one set per cycle. Software or a walker on the refill port handles misses, faults and replacement.

Two reset inputs are provided. The asynchronous power-on reset invalidates every entry. The synchronous manual reset clears only the result registers and leaves all entries as they are.

Top module: `tlb_xlate`

## Requirements
- R1: After the power-on reset (`rst_ni` low), every entry is invalid. Each outcome output is 0 and a lookup at any address reports a miss.
- R2: On a 1 KiB entry (`fill_sz_i`=0), a hit requires va[31:17]==tag_hi and va[11:10]==tag_lo. On a hit, `pa_o` = {ppn[21:0], va[9:0]}, where ppn holds physical address bits 31:10.
- R3: On a 4 KiB entry (`fill_sz_i`=1), va[11:10] is left out of the match. On a hit, `pa_o` = {ppn[21:2], va[11:0]}, and ppn[1:0] is ignored.
- R4: On a non-shared entry (`fill_sh_i`=0), a hit also requires `asid_i` to equal the stored identifier. Otherwise the lookup misses.
- R5: On a shared entry (`fill_sh_i`=1), the identifier comparison is skipped.
- R6: va[16:12] selects one of 32 sets. Entries in other sets never match.
- R7: Each set has 4 ways that are searched in parallel. When several ways match, the lowest-numbered way supplies the result.
- R8: Access-rights code pr: 00 allows a privileged read, 01 allows a privileged read or write, 10 allows a read in either mode, 11 allows a read or write in either mode. A denied access raises `prot_fault_o` with `hit_o` low.
- R9: A permitted write to an entry whose modified flag is 0 raises `dirty_fault_o` with `hit_o` low. Once the entry is refilled with the flag set to 1, the same write hits.
- R10: `mrst_i` high at a clock edge clears all result outputs. The entries, including their valid bits, keep their contents.
- R11: The result of a lookup appears after the next rising clock edge. At most one of hit, miss, rights fault and first-write fault is high. With `req_i` low, all of them are 0 after the edge.
- R12: A refill and a lookup to the same set in the same cycle drop the lookup, so all outcome outputs are 0 after the edge. A refill to a different set does not disturb the lookup.
- R13: `cacheable_o` equals the entry's cacheable flag on a hit and is 0 otherwise. `pa_o` is 0 when there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mrst_i | input | 1 | Synchronous manual reset of the result registers |
| req_i | input | 1 | Lookup request |
| va_i | input | 32 | Virtual address |
| asid_i | input | 8 | Current address-space identifier |
| priv_i | input | 1 | 1 = privileged mode, 0 = user mode |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| fill_en_i | input | 1 | Refill write enable |
| fill_set_i | input | 5 | Set written by the refill |
| fill_way_i | input | 2 | Way written by the refill |
| fill_tag_hi_i | input | 15 | Stored va[31:17] |
| fill_tag_lo_i | input | 2 | Stored va[11:10] |
| fill_asid_i | input | 8 | Stored space identifier |
| fill_sh_i | input | 1 | Shared flag |
| fill_sz_i | input | 1 | Page size, 0 = 1 KiB, 1 = 4 KiB |
| fill_v_i | input | 1 | Valid flag |
| fill_ppn_i | input | 22 | Physical page number, physical address bits 31:10 |
| fill_pr_i | input | 2 | Access-rights code |
| fill_c_i | input | 1 | Cacheable flag |
| fill_d_i | input | 1 | Modified flag |
| hit_o | output | 1 | Translation succeeded |
| miss_o | output | 1 | No matching entry |
| prot_fault_o | output | 1 | Access denied by the rights code |
| dirty_fault_o | output | 1 | First write to an unmodified page |
| pa_o | output | 32 | Physical address |
| cacheable_o | output | 1 | Cacheable flag of the hit entry |

## Verification
On every cycle, the assertions check that the outcome signals are mutually exclusive, that an idle cycle, a manual reset or a same-set refill leaves every outcome low, that a rights fault follows only a user-mode or write access, that a first-write fault follows only a write, and that a hit keeps the page offset. The properties cannot express the contents of the entries. Size-dependent tag matching, identifier sharing, set selection, way priority, the full rights table, survival of the valid bits across a manual reset and their clearing by a power-on reset are therefore shown only by the bench scenarios, which compare the results against physical addresses computed from the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W     = 32;
  localparam int unsigned IDX_LSB  = 12;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned TAGH_LSB = IDX_LSB + IDX_W;
  localparam int unsigned TAGH_W   = VA_W - TAGH_LSB;
  localparam int unsigned TAGL_W   = 2;
  localparam int unsigned ASID_W   = 8;
  localparam int unsigned PPN_W    = 22;
  localparam int unsigned PR_W     = 2;

  typedef struct packed {
    logic [TAGH_W-1:0] tag_hi;
    logic [TAGL_W-1:0] tag_lo;
    logic [ASID_W-1:0] asid;
    logic              sh;
    logic              sz;
    logic [PPN_W-1:0]  ppn;
    logic [PR_W-1:0]   pr;
    logic              c;
    logic              d;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int unsigned SETS  = 32,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned SW   = $clog2(SETS),
  localparam int unsigned WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [SW-1:0]         wset_i,
  input  logic [WW-1:0]         wway_i,
  input  tlb_ent_t              wdata_i,
  input  logic                  wvalid_i,
  input  logic [SW-1:0]         rset_i,
  output tlb_ent_t [WAYS-1:0]   rd_ent_o,
  output logic [WAYS-1:0]       rd_v_o
);
  tlb_ent_t [WAYS-1:0] ent_q [SETS];
  logic     [WAYS-1:0] v_q   [SETS];

  // payload has no reset; valid bits cleared only by power-on reset
  always_ff @(posedge clk_i) begin
    if (we_i) ent_q[wset_i][wway_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) v_q[s] <= '0;
    end else if (we_i) begin
      v_q[wset_i][wway_i] <= wvalid_i;
    end
  end

  assign rd_ent_o = ent_q[rset_i];
  assign rd_v_o   = v_q[rset_i];
endmodule

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp
  import tlb_pkg::*;
(
  input  tlb_ent_t          ent_i,
  input  logic              v_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              match_o
);
  logic hi_eq, lo_eq, asid_ok;

  assign hi_eq   = (ent_i.tag_hi == va_i[VA_W-1:TAGH_LSB]);
  // 4 KiB pages drop va[11:10] from the tag
  assign lo_eq   = ent_i.sz || (ent_i.tag_lo == va_i[11:10]);
  assign asid_ok = ent_i.sh || (ent_i.asid == asid_i);
  assign match_o = v_i && hi_eq && lo_eq && asid_ok;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [PR_W-1:0] pr_i,
  input  logic            priv_i,
  input  logic            wr_i,
  output logic            allow_o
);
  logic user_ok, write_ok;

  assign user_ok  = pr_i[1];
  assign write_ok = pr_i[0];
  assign allow_o  = (priv_i || user_ok) && (!wr_i || write_ok);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  localparam int unsigned SETS = 1 << IDX_W,
  localparam int unsigned WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              priv_i,
  input  logic              wr_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_set_i,
  input  logic [WW-1:0]     fill_way_i,
  input  logic [TAGH_W-1:0] fill_tag_hi_i,
  input  logic [TAGL_W-1:0] fill_tag_lo_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_sh_i,
  input  logic              fill_sz_i,
  input  logic              fill_v_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [PR_W-1:0]   fill_pr_i,
  input  logic              fill_c_i,
  input  logic              fill_d_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              prot_fault_o,
  output logic              dirty_fault_o,
  output logic [VA_W-1:0]   pa_o,
  output logic              cacheable_o
);
  logic [IDX_W-1:0]    set_idx;
  tlb_ent_t            wdata;
  tlb_ent_t [WAYS-1:0] rd_ent;
  logic [WAYS-1:0]     rd_v;
  logic [WAYS-1:0]     match;
  logic                any_match;
  logic [WW-1:0]       sel_way;
  tlb_ent_t            sel;
  logic                allow;
  logic                look;
  logic [VA_W-1:0]     pa_calc;
  logic                hit_d, miss_d, prot_d, dirty_d, c_d;
  logic [VA_W-1:0]     pa_d;

  assign set_idx = va_i[IDX_LSB +: IDX_W];

  assign wdata = '{tag_hi: fill_tag_hi_i, tag_lo: fill_tag_lo_i,
                   asid: fill_asid_i, sh: fill_sh_i, sz: fill_sz_i,
                   ppn: fill_ppn_i, pr: fill_pr_i, c: fill_c_i, d: fill_d_i};

  tlb_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (fill_en_i),
    .wset_i   (fill_set_i),
    .wway_i   (fill_way_i),
    .wdata_i  (wdata),
    .wvalid_i (fill_v_i),
    .rset_i   (set_idx),
    .rd_ent_o (rd_ent),
    .rd_v_o   (rd_v)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way_cmp u_cmp (
      .ent_i   (rd_ent[w]),
      .v_i     (rd_v[w]),
      .va_i    (va_i),
      .asid_i  (asid_i),
      .match_o (match[w])
    );
  end

  // lowest-numbered matching way wins
  always_comb begin
    any_match = 1'b0;
    sel_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        any_match = 1'b1;
        sel_way   = WW'(w);
      end
    end
  end

  assign sel = rd_ent[sel_way];

  tlb_perm u_perm (
    .pr_i    (sel.pr),
    .priv_i  (priv_i),
    .wr_i    (wr_i),
    .allow_o (allow)
  );

  assign pa_calc = sel.sz ? {sel.ppn[PPN_W-1:2], va_i[11:0]}
                          : {sel.ppn, va_i[9:0]};

  // refill to the same set drops the lookup
  assign look    = req_i && !(fill_en_i && (fill_set_i == set_idx));
  assign miss_d  = look && !any_match;
  assign prot_d  = look && any_match && !allow;
  assign dirty_d = look && any_match && allow && wr_i && !sel.d;
  assign hit_d   = look && any_match && allow && !(wr_i && !sel.d);
  assign c_d     = hit_d && sel.c;
  assign pa_d    = hit_d ? pa_calc : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0; miss_o <= 1'b0; prot_fault_o <= 1'b0;
      dirty_fault_o <= 1'b0; pa_o <= '0; cacheable_o <= 1'b0;
    end else if (mrst_i) begin
      hit_o <= 1'b0; miss_o <= 1'b0; prot_fault_o <= 1'b0;
      dirty_fault_o <= 1'b0; pa_o <= '0; cacheable_o <= 1'b0;
    end else begin
      hit_o         <= hit_d;
      miss_o        <= miss_d;
      prot_fault_o  <= prot_d;
      dirty_fault_o <= dirty_d;
      pa_o          <= pa_d;
      cacheable_o   <= c_d;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mrst_i,
  input logic              req_i,
  input logic [VA_W-1:0]   va_i,
  input logic              priv_i,
  input logic              wr_i,
  input logic              fill_en_i,
  input logic [IDX_W-1:0]  fill_set_i,
  input logic              hit_o,
  input logic              miss_o,
  input logic              prot_fault_o,
  input logic              dirty_fault_o,
  input logic [VA_W-1:0]   pa_o,
  input logic              cacheable_o
);
  logic any_out;
  assign any_out = hit_o | miss_o | prot_fault_o | dirty_fault_o;

  a_r11_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, miss_o, prot_fault_o, dirty_fault_o}));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !any_out);

  a_r10_mrst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> (!any_out && pa_o == '0 && !cacheable_o));

  a_r12_fill_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && fill_en_i && fill_set_i == va_i[IDX_LSB +: IDX_W]) |=> !any_out);

  a_r8_prot_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> $past(!priv_i || wr_i));

  a_r9_dirty_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_fault_o |-> $past(wr_i));

  a_r2_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (pa_o[9:0] == $past(va_i[9:0])));

  a_r13_c_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cacheable_o |-> hit_o);
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (.*);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  import tlb_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              mrst = 1'b0;
  logic              req = 1'b0;
  logic [31:0]       va = '0;
  logic [7:0]        asid = '0;
  logic              priv = 1'b0;
  logic              wr = 1'b0;
  logic              f_en = 1'b0;
  logic [4:0]        f_set = '0;
  logic [1:0]        f_way = '0;
  logic [14:0]       f_thi = '0;
  logic [1:0]        f_tlo = '0;
  logic [7:0]        f_asid = '0;
  logic              f_sh = 1'b0, f_sz = 1'b0, f_v = 1'b0;
  logic [21:0]       f_ppn = '0;
  logic [1:0]        f_pr = '0;
  logic              f_c = 1'b0, f_d = 1'b0;
  logic              hit, miss, prot, dirty, cach;
  logic [31:0]       pa;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk_i(clk), .rst_ni(rst_ni), .mrst_i(mrst), .req_i(req), .va_i(va),
    .asid_i(asid), .priv_i(priv), .wr_i(wr), .fill_en_i(f_en),
    .fill_set_i(f_set), .fill_way_i(f_way), .fill_tag_hi_i(f_thi),
    .fill_tag_lo_i(f_tlo), .fill_asid_i(f_asid), .fill_sh_i(f_sh),
    .fill_sz_i(f_sz), .fill_v_i(f_v), .fill_ppn_i(f_ppn), .fill_pr_i(f_pr),
    .fill_c_i(f_c), .fill_d_i(f_d), .hit_o(hit), .miss_o(miss),
    .prot_fault_o(prot), .dirty_fault_o(dirty), .pa_o(pa), .cacheable_o(cach)
  );

  localparam logic [31:0] VA1 = 32'h1234_5678;
  localparam logic [31:0] VA2 = 32'h0ABC_3C00;
  localparam logic [31:0] VA3 = 32'h7654_1000;
  localparam logic [31:0] VA4 = 32'h4000_2400;
  localparam logic [31:0] VA5 = 32'h5000_4800;
  localparam logic [21:0] PPN1 = 22'h2ABCD;
  localparam logic [21:0] PPN2 = 22'h155555;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flags packed as {hit,miss,prot,dirty,c}
  task automatic chk_out(input string tag, input logic [4:0] f, input logic [31:0] epa);
    chk({tag, " flags"}, {27'd0, hit, miss, prot, dirty, cach}, {27'd0, f});
    chk({tag, " pa"}, pa, epa);
  endtask

  task automatic set_fill(input logic [1:0] way, input logic [31:0] fva,
                          input logic [7:0] fa, input logic sh, input logic sz,
                          input logic [21:0] ppn, input logic [1:0] pr,
                          input logic c, input logic d);
    f_en = 1'b1; f_way = way; f_set = fva[16:12]; f_thi = fva[31:17];
    f_tlo = fva[11:10]; f_asid = fa; f_sh = sh; f_sz = sz; f_v = 1'b1;
    f_ppn = ppn; f_pr = pr; f_c = c; f_d = d;
  endtask

  task automatic fill(input logic [1:0] way, input logic [31:0] fva,
                      input logic [7:0] fa, input logic sh, input logic sz,
                      input logic [21:0] ppn, input logic [1:0] pr,
                      input logic c, input logic d);
    @(negedge clk);
    set_fill(way, fva, fa, sh, sz, ppn, pr, c, d);
    @(posedge clk); #1;
    f_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic [7:0] id,
                      input logic p, input logic w);
    @(negedge clk);
    req = 1'b1; va = a; asid = id; priv = p; wr = w;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic t_reset;
    chk_out("R1 reset state", 5'b00000, 32'h0);
    look(VA1, 8'd3, 1'b1, 1'b0);
    chk_out("R1 empty miss", 5'b01000, 32'h0);
  endtask

  task automatic t_small_page;
    fill(2'd0, VA1, 8'd3, 1'b0, 1'b0, PPN1, 2'b11, 1'b1, 1'b1);
    look(VA1, 8'd3, 1'b0, 1'b0);
    chk_out("R2 R13 1k hit", 5'b10001, {PPN1, VA1[9:0]});
    look(VA1 ^ 32'h0000_0400, 8'd3, 1'b0, 1'b0);
    chk_out("R2 1k va10 differs", 5'b01000, 32'h0);
    look(VA1, 8'd3, 1'b0, 1'b1);
    chk_out("R8 user write pr11", 5'b10001, {PPN1, VA1[9:0]});
  endtask

  task automatic t_big_page;
    fill(2'd1, VA2, 8'd7, 1'b1, 1'b1, PPN2, 2'b11, 1'b0, 1'b1);
    look(VA2 ^ 32'h0000_0C00, 8'd7, 1'b1, 1'b0);
    chk_out("R3 R13 4k ignores va11:10", 5'b10000, {PPN2[21:2], VA2[11:0] ^ 12'hC00});
    look(VA2, 8'd9, 1'b1, 1'b0);
    chk_out("R5 shared other asid", 5'b10000, {PPN2[21:2], VA2[11:0]});
  endtask

  task automatic t_asid_set;
    look(VA1, 8'd4, 1'b1, 1'b0);
    chk_out("R4 asid mismatch", 5'b01000, 32'h0);
    look(VA1 ^ 32'h0000_1000, 8'd3, 1'b1, 1'b0);
    chk_out("R6 other set", 5'b01000, 32'h0);
  endtask

  task automatic t_priority;
    fill(2'd3, VA3, 8'd1, 1'b0, 1'b0, 22'h0AAAA, 2'b11, 1'b0, 1'b1);
    fill(2'd2, VA3, 8'd1, 1'b0, 1'b0, 22'h05555, 2'b11, 1'b0, 1'b1);
    look(VA3, 8'd1, 1'b1, 1'b0);
    chk_out("R7 lowest way", 5'b10000, {22'h05555, VA3[9:0]});
  endtask

  task automatic t_rights;
    logic [31:0] epa;
    epa = {22'h01234, VA4[9:0]};
    fill(2'd0, VA4, 8'd5, 1'b0, 1'b0, 22'h01234, 2'b00, 1'b0, 1'b1);
    look(VA4, 8'd5, 1'b0, 1'b0);
    chk_out("R8 pr00 user read", 5'b00100, 32'h0);
    look(VA4, 8'd5, 1'b1, 1'b0);
    chk_out("R8 pr00 priv read", 5'b10000, epa);
    look(VA4, 8'd5, 1'b1, 1'b1);
    chk_out("R8 pr00 priv write", 5'b00100, 32'h0);
    fill(2'd0, VA4, 8'd5, 1'b0, 1'b0, 22'h01234, 2'b01, 1'b0, 1'b1);
    look(VA4, 8'd5, 1'b1, 1'b1);
    chk_out("R8 pr01 priv write", 5'b10000, epa);
    look(VA4, 8'd5, 1'b0, 1'b0);
    chk_out("R8 pr01 user read", 5'b00100, 32'h0);
    fill(2'd0, VA4, 8'd5, 1'b0, 1'b0, 22'h01234, 2'b10, 1'b0, 1'b1);
    look(VA4, 8'd5, 1'b0, 1'b0);
    chk_out("R8 pr10 user read", 5'b10000, epa);
    look(VA4, 8'd5, 1'b0, 1'b1);
    chk_out("R8 pr10 user write", 5'b00100, 32'h0);
  endtask

  task automatic t_first_write;
    fill(2'd0, VA5, 8'd2, 1'b0, 1'b0, 22'h3FFFF, 2'b11, 1'b1, 1'b0);
    look(VA5, 8'd2, 1'b0, 1'b1);
    chk_out("R9 clean write", 5'b00010, 32'h0);
    look(VA5, 8'd2, 1'b0, 1'b0);
    chk_out("R9 clean read", 5'b10001, {22'h3FFFF, VA5[9:0]});
    fill(2'd0, VA5, 8'd2, 1'b0, 1'b0, 22'h3FFFF, 2'b11, 1'b1, 1'b1);
    look(VA5, 8'd2, 1'b0, 1'b1);
    chk_out("R9 dirty write", 5'b10001, {22'h3FFFF, VA5[9:0]});
  endtask

  task automatic t_conflict;
    @(negedge clk);
    set_fill(2'd3, VA1 ^ 32'h8000_0000, 8'd3, 1'b0, 1'b0, 22'h0, 2'b11, 1'b0, 1'b1);
    req = 1'b1; va = VA1; asid = 8'd3; priv = 1'b1; wr = 1'b0;
    @(posedge clk); #1;
    req = 1'b0; f_en = 1'b0;
    chk_out("R12 same set dropped", 5'b00000, 32'h0);
    @(negedge clk);
    set_fill(2'd1, VA5, 8'd2, 1'b0, 1'b0, 22'h0, 2'b11, 1'b0, 1'b1);
    req = 1'b1; va = VA1;
    @(posedge clk); #1;
    req = 1'b0; f_en = 1'b0;
    chk_out("R12 other set proceeds", 5'b10001, {PPN1, VA1[9:0]});
    @(posedge clk); #1;
    chk_out("R11 idle after hit", 5'b00000, 32'h0);
  endtask

  task automatic t_manual_reset;
    @(negedge clk);
    req = 1'b1; va = VA1; asid = 8'd3; priv = 1'b1; wr = 1'b0; mrst = 1'b1;
    @(posedge clk); #1;
    req = 1'b0; mrst = 1'b0;
    chk_out("R10 mrst clears outputs", 5'b00000, 32'h0);
    look(VA1, 8'd3, 1'b1, 1'b0);
    chk_out("R10 entry survives mrst", 5'b10001, {PPN1, VA1[9:0]});
  endtask

  task automatic t_power_reset;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk_out("R1 async clear", 5'b00000, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    look(VA1, 8'd3, 1'b1, 1'b0);
    chk_out("R1 entry gone va1", 5'b01000, 32'h0);
    look(VA2, 8'd7, 1'b1, 1'b0);
    chk_out("R1 entry gone va2", 5'b01000, 32'h0);
  endtask

  task automatic run_all;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_small_page();
    t_big_page();
    t_asid_set();
    t_priority();
    t_rights();
    t_first_write();
    t_conflict();
    t_manual_reset();
    t_power_reset();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule